// File: doc/BRIEF.md
# Countdown Event Timer

This block is a down-counting event timer driven by a one-microsecond tick strobe. Software programs it with a single word. That word holds a run enable, an auto-reload mode flag and a load value equal to the wanted number of ticks minus one. The count then steps down once per tick. When a tick arrives while the count is already zero, the timer expires and latches a pending interrupt, which drives a level-high interrupt line.

In one-shot mode, expiry drops the enable and leaves the count parked at zero. In periodic mode, expiry reloads the programmed value and the timer keeps running, so the period is exactly the programmed number of ticks. A second register word reports the live count together with the pending flag. Writing that word with its clear bit set acknowledges the interrupt. Writing all zeros to the preset word halts the timer.

Top module: `evt_countdown_timer`

## Requirements
- R1: After reset the count, enable, mode and load value are zero, the interrupt line is low, and both register words read as zero.
- R2: A write to byte offset 0x0 (the preset word) stores bit 31 as enable, bit 30 as periodic mode (1 = periodic) and bits [28:0] as the load value. On the next cycle the count equals that load value, even when the timer was already running.
- R3: While enabled, each cycle with `tick_i` high lowers a non-zero count by exactly one. Cycles without a tick, and all cycles while disabled, leave the count unchanged.
- R4: A load value of N-1 makes the timer expire on the Nth tick after the preset write. A load value of 0 expires on the first tick, and the interrupt stays low before expiry.
- R5: Expiry sets the pending flag, and `irq_o` is high whenever the flag is set. The flag stays set until it is cleared.
- R6: On one-shot expiry the enable bit reads back as 0 and the count stays at 0. Later ticks change nothing.
- R7: On periodic expiry the count reloads the load value and the enable stays set, so expiries repeat every N ticks.
- R8: Writing 0 to the preset word stops the timer: the enable reads 0 and the count reads 0. Later ticks have no effect, and a pending interrupt is left untouched.
- R9: A write to byte offset 0x4 with bit 30 set clears the pending flag. With bit 30 clear, the write has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: Reading offset 0x4 returns the live count in bits [28:0], the pending flag in bit 30 and zero elsewhere. Reading offset 0x0 returns the live enable in bit 31, the mode in bit 30, the load value in bits [28:0] and zero elsewhere.
- R11: The largest load value, 0x1FFFFFFF, is held in full and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle microsecond tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Byte offset of the read |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Level-high interrupt |

## Verification
On every cycle, the assertions check the following: a preset write restarts the count, each tick steps the count down by one, the count holds when no tick applies, expiry raises the interrupt, one-shot expiry stops the timer and periodic expiry reloads it, and a clear drops the flag unless an expiry hits in the same cycle. Some behaviour only the bench scenarios can show. These are the exact tick on which expiry lands for a given load value, the register read layout, that stopping leaves a pending interrupt alone, and that the largest load value survives. The bench covers them with directed cases and with a random mix of writes, clears and ticks compared against its own model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int TMR_DATA_W = 32;
  localparam int TMR_CNT_W  = 29;
  localparam int TMR_ADDR_W = 4;

  // byte offsets of the two register words
  localparam int OFS_PRESET = 0;
  localparam int OFS_STATUS = 4;

  typedef enum logic {
    RUN_ONESHOT  = 1'b0,
    RUN_PERIODIC = 1'b1
  } run_mode_e;

endpackage

// File: rtl/evt_tmr_ctrl.sv
module evt_tmr_ctrl
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = TMR_CNT_W,
  parameter int DATA_W = TMR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_we_i,
  input  logic [DATA_W-1:0] preset_wdata_i,
  input  logic              oneshot_done_i,
  output logic              enable_o,
  output run_mode_e         mode_o,
  output logic [CNT_W-1:0]  reload_o
);

  localparam int EN_BIT  = DATA_W - 1;
  localparam int PER_BIT = DATA_W - 2;

  logic unused_gap_bits;
  assign unused_gap_bits = ^preset_wdata_i[PER_BIT-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      mode_o   <= RUN_ONESHOT;
      reload_o <= '0;
    end else if (preset_we_i) begin
      enable_o <= preset_wdata_i[EN_BIT];
      mode_o   <= run_mode_e'(preset_wdata_i[PER_BIT]);
      reload_o <= preset_wdata_i[CNT_W-1:0];
    end else if (oneshot_done_i) begin
      enable_o <= 1'b0;
    end
  end

endmodule

// File: rtl/evt_tmr_core.sv
module evt_tmr_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  run_mode_e        mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  function automatic logic is_spent(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic             advance_w;
  logic [CNT_W-1:0] count_d;

  assign advance_w = tick_i & enable_i & ~load_i;
  assign expire_o  = advance_w & is_spent(count_o);

  always_comb begin
    count_d = count_o;
    if (load_i) begin
      count_d = load_val_i;
    end else if (expire_o) begin
      if (mode_i == RUN_PERIODIC) count_d = reload_i;
    end else if (advance_w) begin
      count_d = step_down(count_o);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_d;
  end

endmodule

// File: rtl/evt_tmr_irq.sv
module evt_tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = TMR_CNT_W,
  parameter int DATA_W = TMR_DATA_W,
  parameter int ADDR_W = TMR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  localparam int EN_BIT  = DATA_W - 1;
  localparam int MODE_BIT = DATA_W - 2;
  localparam int CLR_BIT = DATA_W - 2;
  localparam logic [ADDR_W-1:0] A_PRESET = ADDR_W'(OFS_PRESET);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  // named internal events, also observed by the bound checker
  logic             load_w;
  logic             clr_w;
  logic             expire_w;
  logic             oneshot_done_w;
  logic             periodic_w;
  logic             enable_q;
  run_mode_e        mode_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;

  assign load_w         = wr_en_i & (wr_addr_i == A_PRESET);
  assign clr_w          = wr_en_i & (wr_addr_i == A_STATUS) & wr_data_i[CLR_BIT];
  assign periodic_w     = (mode_q == RUN_PERIODIC);
  assign oneshot_done_w = expire_w & ~periodic_w;

  evt_tmr_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .preset_we_i    (load_w),
    .preset_wdata_i (wr_data_i),
    .oneshot_done_i (oneshot_done_w),
    .enable_o       (enable_q),
    .mode_o         (mode_q),
    .reload_o       (reload_q)
  );

  evt_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .enable_i   (enable_q),
    .mode_i     (mode_q),
    .load_i     (load_w),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .reload_i   (reload_q),
    .count_o    (count_q),
    .expire_o   (expire_w)
  );

  evt_tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (expire_w),
    .clr_i  (clr_w),
    .pend_o (irq_o)
  );

  function automatic logic [DATA_W-1:0] pack_preset(
    input logic en, input logic per, input logic [CNT_W-1:0] val);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = val;
    w[MODE_BIT]  = per;
    w[EN_BIT]    = en;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
    input logic pend, input logic [CNT_W-1:0] cnt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = cnt;
    w[CLR_BIT]   = pend;
    return w;
  endfunction

  always_comb begin
    unique case (rd_addr_i)
      A_PRESET: rd_data_o = pack_preset(enable_q, periodic_w, reload_q);
      A_STATUS: rd_data_o = pack_status(irq_o, count_q);
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             load_w,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             enable_q,
  input logic             periodic_w,
  input logic             expire_w,
  input logic             clr_w,
  input logic             irq_o
);

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> count_q == $past(load_val)); // R2

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && tick_i && !load_w && count_q != '0)
      |=> count_q == $past(count_q) - CNT_W'(1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_w && !(tick_i && enable_q)) |=> $stable(count_q)); // R3

  AST_EXPIRE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> irq_o); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_w) |=> irq_o); // R5

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !periodic_w) |=> (!enable_q && count_q == '0)); // R6

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && periodic_w) |=> (enable_q && count_q == $past(reload_q))); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !expire_w) |=> !irq_o); // R9

endmodule

bind evt_countdown_timer evt_timer_checker #(.CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .load_w     (load_w),
  .load_val   (wr_data_i[CNT_W-1:0]),
  .count_q    (count_q),
  .reload_q   (reload_q),
  .enable_q   (enable_q),
  .periodic_w (periodic_w),
  .expire_w   (expire_w),
  .clr_w      (clr_w),
  .irq_o      (irq_o)
);

// File: tb/tb_evt_countdown_timer.sv
module tb_evt_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk; // 50 MHz

  evt_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // bench model, built from the requirements
  logic [28:0] m_cnt = '0;
  logic [28:0] m_load = '0;
  logic        m_en = 1'b0;
  logic        m_per = 1'b0;
  logic        m_irq = 1'b0;

  function automatic logic [31:0] exp_preset();
    return {m_en, m_per, 1'b0, m_load};
  endfunction

  function automatic logic [31:0] exp_status();
    return {1'b0, m_irq, 1'b0, m_cnt};
  endfunction

  task automatic model_step(input bit wp, input bit wc, input logic [31:0] d, input bit tk);
    bit fire;
    fire = tk && m_en && (m_cnt == 0) && !wp;
    if (wp) begin
      m_en = d[31]; m_per = d[30]; m_load = d[28:0]; m_cnt = d[28:0];
    end else if (tk && m_en) begin
      if (m_cnt == 0) begin
        if (m_per) m_cnt = m_load;
        else       m_en = 1'b0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (fire) m_irq = 1'b1;
    else if (wc && d[30]) m_irq = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic compare_model();
    logic [31:0] v;
    rd(4'h0, v); chk("R10 preset word vs model", v, exp_preset());
    rd(4'h4, v); chk("R10 status word vs model", v, exp_status());
    chk("R5 irq line vs model", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  // one clock: wp = preset write, wc = status write, tk = tick
  task automatic cycle(input bit wp, input bit wc, input logic [31:0] d, input bit tk);
    @(negedge clk);
    wr_en_i   = wp | wc;
    wr_addr_i = wp ? 4'h0 : 4'h4;
    wr_data_i = d;
    tick_i    = tk;
    model_step(wp, wc, d, tk);
    @(posedge clk);
    #2;
    wr_en_i = 1'b0;
    tick_i  = 1'b0;
    compare_model();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 32'h0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    rd(4'h0, v); chk("R1 preset after reset", v, 32'h0);
    rd(4'h4, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    // R2 load, R3 hold without tick, R4 expiry on 4th tick
    cycle(1, 0, 32'h8000_0003, 0);
    rd(4'h4, v); chk("R2 count after load", v, 32'h3);
    rd(4'h0, v); chk("R2 preset readback", v, 32'h8000_0003);
    cycle(0, 0, 32'h0, 0); cycle(0, 0, 32'h0, 0);
    rd(4'h4, v); chk("R3 hold without tick", v, 32'h3);
    ticks(3);
    rd(4'h4, v); chk("R3 count after 3 ticks", v, 32'h0);
    chk("R4 no irq before Nth tick", {31'b0, irq_o}, 32'h0);
    ticks(1);
    chk("R4 irq on Nth tick", {31'b0, irq_o}, 32'h1);
    rd(4'h0, v); chk("R6 enable cleared one-shot", v, 32'h0000_0003);
    rd(4'h4, v); chk("R10 status layout pending", v, 32'h4000_0000);
    ticks(2);
    rd(4'h4, v); chk("R6 stays parked", v, 32'h4000_0000);
    chk("R5 irq level held", {31'b0, irq_o}, 32'h1);

    // R9 clear semantics
    cycle(0, 1, 32'hBFFF_FFFF, 0);
    chk("R9 write without clear bit", {31'b0, irq_o}, 32'h1);
    cycle(0, 1, 32'h4000_0000, 0);
    chk("R9 clear bit drops irq", {31'b0, irq_o}, 32'h0);

    // R7 periodic
    cycle(1, 0, 32'hC000_0002, 0);
    ticks(3);
    chk("R7 first periodic expiry", {31'b0, irq_o}, 32'h1);
    rd(4'h4, v); chk("R7 reloaded count", v, 32'h4000_0002);
    rd(4'h0, v); chk("R7 enable kept", v, 32'hC000_0002);
    cycle(0, 1, 32'h4000_0000, 0);
    ticks(2);
    chk("R7 no early second expiry", {31'b0, irq_o}, 32'h0);
    ticks(1);
    chk("R7 second expiry", {31'b0, irq_o}, 32'h1);

    // R2 restart while running
    ticks(1);
    cycle(1, 0, 32'h8000_0005, 0);
    rd(4'h4, v); chk("R2 restart while running", v, 32'h4000_0005);

    // R8 stop keeps pending
    cycle(1, 0, 32'h0, 0);
    rd(4'h0, v); chk("R8 stop preset", v, 32'h0);
    ticks(3);
    rd(4'h4, v); chk("R8 stopped, pending kept", v, 32'h4000_0000);
    cycle(0, 1, 32'h4000_0000, 0);

    // R9 expiry wins over clear in the same cycle
    cycle(1, 0, 32'hC000_0000, 0);
    cycle(0, 1, 32'h4000_0000, 1);
    chk("R9 set wins over clear", {31'b0, irq_o}, 32'h1);
    cycle(0, 1, 32'h4000_0000, 0);
    chk("R9 later clear", {31'b0, irq_o}, 32'h0);

    // R11 largest load
    cycle(1, 0, 32'h9FFF_FFFF, 0);
    rd(4'h4, v); chk("R11 max load held", v, 32'h1FFF_FFFF);
    ticks(1);
    rd(4'h4, v); chk("R11 max load decrements", v, 32'h1FFF_FFFE);
    cycle(1, 0, 32'h0, 0);

    // random mix against the model (R3, R4, R6, R7, R9, R10)
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 8;
      d = '0;
      if (op == 0) begin
        d[31] = ($urandom % 4) != 0;
        d[30] = $urandom % 2;
        d[28:0] = 29'($urandom % 6);
        cycle(1, 0, d, $urandom % 2);
      end else if (op == 1) begin
        d = $urandom;
        cycle(0, 1, d, $urandom % 2);
      end else begin
        cycle(0, 0, 32'h0, $urandom % 2);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule